// File: doc/BRIEF.md
# Keyed-Configuration Reset Pulse Shaper

This block turns a single-cycle trigger from a watchdog timer into an external reset pulse of programmable length. The length is counted in ticks of a slow time base, for example a 1 MHz enable strobe. Once started, the pulse stays asserted for the programmed width value plus one tick. The register default of 255 therefore gives a 256-tick pulse. A trigger that arrives while a pulse is running is dropped.

The block holds a single 32-bit configuration word. It is written and read without an address, because the surrounding register decoder selects it.
- The low field always takes the written width.
- The two upper flag bits, output polarity and drive mode, read back as plain bits. Writing them has no direct effect. A flag changes only when the top byte of a write carries one of four key values.
- Keys are needed so that a routine write of the width cannot silently change how the pad behaves.

The output pair drives a pad. In push-pull mode the output enable stays high and the level follows the polarity. In open-drain mode the pin value is held low and only the enable moves, so an external pull-up supplies the high level.

Top module: `rpulse_shaper`

## Requirements
- R1: After reset the configuration reads 0x000000FF: the width is 255, bit 31 (active-high flag) is 0, and bit 30 (push-pull flag) is 0, which means the output is active low and open-drain.
- R2: Every write loads bits [WIDTH_BITS-1:0] (default [19:0]) into the width field, whatever the top byte holds. Bits 29 down to WIDTH_BITS always read 0.
- R3: A write with top byte 0xA5 sets the active-high flag (bit 31). A write with top byte 0x5A clears it.
- R4: A write with top byte 0xA8 sets the push-pull flag (bit 30). A write with top byte 0x8A clears it.
- R5: A write whose top byte is none of the four keys leaves both flags unchanged.
- R6: When no pulse is running, a trigger starts one in the next cycle. The pulse lasts until width+1 ticks have been counted after the start.
- R7: A trigger that arrives while a pulse is running has no effect on that pulse's length and does not start a new one.
- R8: In push-pull mode the output enable is 1. The pin equals the active-high flag while asserted and its inverse otherwise.
- R9: In open-drain mode the pin value is 0. With active-low polarity the enable is 1 only while asserted. With active-high polarity the enable is 0 only while asserted.
- R10: The width is captured when a pulse starts. A write during a pulse changes the readback but not the length of the running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Write data: top byte is the key, low bits are the width |
| rd_data_o | output | 32 | Configuration readback |
| trig_i | input | 1 | Pulse request from the watchdog counter |
| tick_i | input | 1 | Time-base enable; one pulse tick per high cycle |
| pin_o | output | 1 | Pad output value |
| pin_oe_o | output | 1 | Pad output enable |

## Verification
The assertions assume three things about the inputs:
- `trig_i` and `tick_i` are synchronous single-clock-domain signals.
- A write is a one-cycle strobe with its data valid in that cycle.
- Ticks may arrive on any cycle, including back to back.

The stimulus stays within these limits. It drives every input on the falling clock edge and holds `tick_i` low in the cycle a trigger is raised, so the start of a pulse is unambiguous. Widths are kept small in the random part so that every pulse finishes in a bounded number of ticks. Tick spacing varies from every cycle to every third cycle, so the tick-counting condition is exercised under different cadences rather than a single one.

// File: rtl/rpulse_pkg.sv
package rpulse_pkg;
    // Top-byte keys that move the mode flags
    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PUSH = 8'hA8;
    localparam logic [7:0] KEY_DRV_OPEN = 8'h8A;
endpackage

// File: rtl/rpulse_cfg.sv
module rpulse_cfg
    import rpulse_pkg::*;
#(
    parameter int WIDTH_BITS = 20,
    parameter logic [WIDTH_BITS-1:0] RESET_WIDTH = 'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [31:0]           wr_data_i,
    output logic [31:0]           rd_data_o,
    output logic                  pol_hi_o,
    output logic                  push_pull_o,
    output logic [WIDTH_BITS-1:0] width_o
);
    localparam int RSV_BITS = 30 - WIDTH_BITS;

    typedef struct packed {
        logic                  pol_hi;
        logic                  push_pull;
        logic [WIDTH_BITS-1:0] width;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [7:0] key;

    assign key = wr_data_i[31:24];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            cfg_d.width = wr_data_i[WIDTH_BITS-1:0];
            case (key)
                KEY_POL_HIGH: cfg_d.pol_hi    = 1'b1;
                KEY_POL_LOW:  cfg_d.pol_hi    = 1'b0;
                KEY_DRV_PUSH: cfg_d.push_pull = 1'b1;
                KEY_DRV_OPEN: cfg_d.push_pull = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{pol_hi: 1'b0, push_pull: 1'b0, width: RESET_WIDTH};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_data_o   = {cfg_q.pol_hi, cfg_q.push_pull, {RSV_BITS{1'b0}}, cfg_q.width};
    assign pol_hi_o    = cfg_q.pol_hi;
    assign push_pull_o = cfg_q.push_pull;
    assign width_o     = cfg_q.width;

    AST_KEY_POL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && key == KEY_POL_HIGH |=> pol_hi_o); // R3
    AST_KEY_POL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && key == KEY_POL_LOW |=> !pol_hi_o); // R3
    AST_KEY_DRV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && key == KEY_DRV_PUSH |=> push_pull_o); // R4
    AST_NONKEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && key != KEY_POL_HIGH && key != KEY_POL_LOW &&
        key != KEY_DRV_PUSH && key != KEY_DRV_OPEN
        |=> $stable(pol_hi_o) && $stable(push_pull_o)); // R5
endmodule

// File: rtl/rpulse_gen.sv
module rpulse_gen #(
    parameter int WIDTH_BITS = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_i,
    input  logic                  tick_i,
    input  logic [WIDTH_BITS-1:0] width_i,
    output logic                  active_o
);
    typedef struct packed {
        logic                  active;
        logic [WIDTH_BITS-1:0] cnt;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (!gen_q.active) begin
            if (trig_i) begin
                gen_d.active = 1'b1;
                gen_d.cnt    = width_i;
            end
        end else if (tick_i) begin
            if (gen_q.cnt == '0) begin
                gen_d.active = 1'b0;
            end else begin
                gen_d.cnt = gen_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign active_o = gen_q.active;

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_q.active && trig_i |=> gen_q.active && gen_q.cnt == $past(width_i)); // R6
    AST_LAST_TICK_END: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q.active && tick_i && gen_q.cnt == '0 |=> !gen_q.active); // R6
    AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q.active && trig_i && !tick_i |=> gen_q.active && $stable(gen_q.cnt)); // R7
endmodule

// File: rtl/rpulse_pad.sv
module rpulse_pad (
    input  logic asserted_i,
    input  logic pol_hi_i,
    input  logic push_pull_i,
    output logic pin_o,
    output logic pin_oe_o
);
    always_comb begin
        if (push_pull_i) begin
            pin_oe_o = 1'b1;
            pin_o    = pol_hi_i ? asserted_i : !asserted_i;
        end else begin
            pin_o    = 1'b0;
            pin_oe_o = pol_hi_i ? !asserted_i : asserted_i;
        end
    end
endmodule

// File: rtl/rpulse_shaper.sv
module rpulse_shaper #(
    parameter int WIDTH_BITS = 20,
    parameter logic [WIDTH_BITS-1:0] RESET_WIDTH = 'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    input  logic        trig_i,
    input  logic        tick_i,
    output logic        pin_o,
    output logic        pin_oe_o
);
    logic                  pol_hi;
    logic                  push_pull;
    logic [WIDTH_BITS-1:0] width;
    logic                  active;

    rpulse_cfg #(.WIDTH_BITS(WIDTH_BITS), .RESET_WIDTH(RESET_WIDTH)) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .pol_hi_o(pol_hi), .push_pull_o(push_pull),
        .width_o(width)
    );

    rpulse_gen #(.WIDTH_BITS(WIDTH_BITS)) i_gen (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .tick_i(tick_i),
        .width_i(width), .active_o(active)
    );

    rpulse_pad i_pad (
        .asserted_i(active), .pol_hi_i(pol_hi), .push_pull_i(push_pull),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o)
    );

    AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> pin_oe_o); // R8
    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !push_pull |-> !pin_o); // R9
endmodule

// File: tb/test_rpulse_shaper.sv
module test_rpulse_shaper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic        trig_i = 1'b0;
    logic        tick_i = 1'b0;
    logic        pin_o;
    logic        pin_oe_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // bench model of the configuration
    logic        m_pol = 1'b0;
    logic        m_pp = 1'b0;
    logic [19:0] m_width = 20'hFF;

    rpulse_shaper i_rpulse_shaper (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .trig_i(trig_i), .tick_i(tick_i),
        .pin_o(pin_o), .pin_oe_o(pin_oe_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    function automatic logic [31:0] exp_rd();
        return {m_pol, m_pp, 10'b0, m_width};
    endfunction

    // asserted state seen at the pad (pull-up in open-drain)
    function automatic logic pad_asserted(input logic p, input logic oe);
        if (m_pp) return (p == m_pol);
        return m_pol ? !oe : oe;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [31:0] d);
        m_width = d[19:0];
        case (d[31:24])
            8'hA5: m_pol = 1'b1;
            8'h5A: m_pol = 1'b0;
            8'hA8: m_pp  = 1'b1;
            8'h8A: m_pp  = 1'b0;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        model_write(d);
        check(req, rd_data_o, exp_rd());
    endtask

    // pad static levels for current mode (R8 / R9)
    task automatic check_pad_mode(input string req);
        if (m_pp) check(req, {31'b0, pin_oe_o}, 32'd1);
        else      check(req, {31'b0, pin_o}, 32'd0);
    endtask

    task automatic pulse(input int period, input bit retrig, input bit midwr);
        int exp_ticks;
        int ticks;
        int c;
        logic [19:0] new_w;
        exp_ticks = int'(m_width) + 1;
        ticks = 0;
        new_w = 20'd3;
        @(negedge clk);
        check_pad_mode("R8/R9 idle");
        check("R6 idle deasserted", {31'b0, pad_asserted(pin_o, pin_oe_o)}, 32'd0);
        tick_i = 1'b0;
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        check("R6 asserted after trigger", {31'b0, pad_asserted(pin_o, pin_oe_o)}, 32'd1);
        check_pad_mode("R8/R9 active");
        c = 0;
        while (pad_asserted(pin_o, pin_oe_o) && c < 5000) begin
            tick_i = ((c % period) == period - 1);
            if (tick_i) ticks++;
            trig_i = retrig && exp_ticks >= 4 && (c == 2);
            wr_en_i = midwr && exp_ticks >= 4 && (c == 3);
            wr_data_i = {8'h00, 4'h0, new_w};
            if (wr_en_i) model_write(wr_data_i);
            c++;
            @(negedge clk);
        end
        tick_i = 1'b0;
        trig_i = 1'b0;
        wr_en_i = 1'b0;
        if (retrig) check("R7 retrigger ignored: ticks", ticks, exp_ticks);
        else if (midwr) check("R10 width captured: ticks", ticks, exp_ticks);
        else check("R6 pulse length in ticks", ticks, exp_ticks);
        repeat (3) @(negedge clk);
        check("R7 no new pulse", {31'b0, pad_asserted(pin_o, pin_oe_o)}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check("R1 reset readback", rd_data_o, 32'h0000_00FF);
        check("R9 reset pad released", {30'b0, pin_o, pin_oe_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: default 256-tick pulse, active-low open-drain
        pulse(1, 1'b0, 1'b0);
        wr(32'h3FFF_FFF0, "R2 width written, reserved zero");
        wr(32'hA500_0000, "R3 active-high key");
        wr(32'hA800_0002, "R4 push-pull key");
        wr(32'h1200_0005, "R5 non-key holds flags");
        pulse(2, 1'b0, 1'b0);
        wr(32'h5A00_0000, "R3 active-low key");
        pulse(1, 1'b0, 1'b0);
        wr(32'h8A00_0006, "R4 open-drain key");
        pulse(3, 1'b1, 1'b0);
        wr(32'hA500_0007, "R3 active-high open-drain");
        pulse(1, 1'b0, 1'b1);
        wr(32'hA5FF_FFFF, "R2 reserved bits masked");
        wr(32'hA500_0004, "R2 width rewrite");

        // random part
        for (int i = 0; i < 40; i++) begin
            logic [7:0] top;
            logic [31:0] d;
            case ($urandom % 5)
                0: top = 8'hA5;
                1: top = 8'h5A;
                2: top = 8'hA8;
                3: top = 8'h8A;
                default: top = 8'($urandom);
            endcase
            d = {top, 4'($urandom), 20'($urandom % 12)};
            wr(d, "R5 random write readback");
            pulse(1 + int'($urandom % 3), 1'($urandom), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule